// File: doc/BRIEF.md
# Display Blink Timing Controller

This block turns the display driver's clock ticks into a slow blink waveform and applies that waveform to the display output path. A 2-bit rate code selects blinking off or one of three blink rates. A power-saving flag picks the matching divider family, so six divide ratios are available in total. A mode bit chooses how the blink shows. In blanking mode the display is blanked during the second half of each blink period. In bank mode the display stays lit, and a bank select toggles between the primary and secondary display RAM bank.

A separate display-enable input blanks the display at any time, whatever the blink state. An external controller can use it to blink the display by toggling it. The divider advances only in cycles where `tick_en` is high, so the blink period is counted in driver-clock ticks rather than system-clock cycles. All pins are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `blink_timing_ctrl`

## Requirements
- R1: With `rate_code` = 2'b00, blinking is off: `bank_sel` is 0 and `disp_blank` equals the inverse of `disp_on`.
- R2: With `low_power` = 0, rate codes 2'b01, 2'b10 and 2'b11 give full blink periods of 6·BASE_DIV, 12·BASE_DIV and 24·BASE_DIV ticks. With the defaults (BASE_DIV = 15360, NORM_MULT = 6) these are 92160, 184320 and 368640 ticks.
- R3: With `low_power` = 1, rate codes 2'b01, 2'b10 and 2'b11 give full blink periods of BASE_DIV, 2·BASE_DIV and 4·BASE_DIV ticks (15360, 30720 and 61440 with the defaults).
- R4: The blink phase has a 50% duty cycle. It toggles after exactly half the selected period of ticks, and it does not change in cycles where `tick_en` is 0.
- R5: With `bank_mode` = 0, `disp_blank` is 1 during the second half of each blink period and 0 during the first half (when `disp_on` = 1). `bank_sel` stays 0.
- R6: With `bank_mode` = 1, `bank_sel` is 1 during the second half of each blink period and 0 during the first half. Blinking never asserts `disp_blank`.
- R7: With `disp_on` = 0, `disp_blank` is 1 in every rate and mode.
- R8: A change of `rate_code` takes effect in the same cycle: the display shows the visible, bank-0 state at once. The period count restarts from zero at the next clock edge.
- R9: A change of `low_power` alone does not restart the count. If the running count has already reached the new half period, the phase toggles on the next tick.
- R10: After reset, the blink phase is in its first half and the count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Driver-clock tick; the divider advances only when high |
| rate_code | input | 2 | Blink rate: 00 off, 01 fastest, 10 middle, 11 slowest |
| bank_mode | input | 1 | 0 blank-and-restore blinking, 1 alternate-bank blinking |
| low_power | input | 1 | 1 selects the power-saving divider family |
| disp_on | input | 1 | Display enable; 0 blanks the display |
| disp_blank | output | 1 | 1 blanks the display outputs |
| bank_sel | output | 1 | Display RAM bank to show: 0 primary, 1 secondary |

## Verification
Some properties are checked by assertions on every cycle. A rate change clears the count and phase. The phase holds in cycles without a tick. A stopped divider stays in phase zero. `disp_on` low forces blanking, and `bank_sel` only rises in bank mode while a rate is selected. Other behaviour is only visible in the bench scenarios. These include the exact half-period lengths for all six ratios and the equal high and low times. They also include the same-cycle masking after a rate change, and the immediate wrap when the power family switches from a long half period to a short one. The bench compares every cycle of a random run against a tick-level model and measures each ratio directly.

// File: rtl/blink_pkg.sv
package blink_pkg;
  typedef enum logic [1:0] {
    RATE_OFF  = 2'b00,
    RATE_FAST = 2'b01,
    RATE_MID  = 2'b10,
    RATE_SLOW = 2'b11
  } rate_e;

  localparam int unsigned NUM_RATES = 3;
endpackage

// File: rtl/blink_ratio_sel.sv
module blink_ratio_sel #(
  parameter int unsigned BASE_DIV  = 15360,
  parameter int unsigned NORM_MULT = 6,
  parameter int unsigned CW        = 18
) (
  input  logic [1:0]    rate_code,
  input  logic          low_power,
  output logic [CW-1:0] half_lim
);
  import blink_pkg::*;

  logic [CW-1:0] lim_ps [NUM_RATES+1];
  logic [CW-1:0] lim_nm [NUM_RATES+1];

  assign lim_ps[0] = '0;
  assign lim_nm[0] = '0;

  // Each rate step doubles the period; half of it is the toggle interval.
  for (genvar k = 1; k <= NUM_RATES; k++) begin : g_lim
    localparam longint unsigned PS_HALF = (longint'(BASE_DIV) << (k - 1)) / 2;
    localparam longint unsigned NM_HALF = (longint'(BASE_DIV) * NORM_MULT << (k - 1)) / 2;
    assign lim_ps[k] = CW'(PS_HALF);
    assign lim_nm[k] = CW'(NM_HALF);
  end

  always_comb begin
    half_lim = low_power ? lim_ps[rate_code] : lim_nm[rate_code];
  end
endmodule

// File: rtl/blink_divider.sv
module blink_divider #(
  parameter int unsigned CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] half_lim,
  output logic          phase
);
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt >= half_lim - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run || restart) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (tick_en) begin
      if (wrap) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt   <= cnt + CW'(1);
      end
    end
  end

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && !phase));

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && run && !restart) |=> $stable(phase));

  // R1
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !phase);

  // R10
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0 && !phase));
endmodule

// File: rtl/blink_out_map.sv
module blink_out_map (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic run,
  input  logic restart,
  input  logic bank_mode,
  input  logic disp_on,
  output logic disp_blank,
  output logic bank_sel
);
  logic eff_phase;

  // A pending restart masks the old phase so the new rate starts visible.
  assign eff_phase  = phase & run & ~restart;
  assign disp_blank = ~disp_on | (eff_phase & ~bank_mode);
  assign bank_sel   = eff_phase & bank_mode;

  // R7
  disp_off_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> disp_blank);

  // R1
  off_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !bank_sel);

  // R6
  bank_only_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel |-> (bank_mode && !(disp_blank && disp_on)));
endmodule

// File: rtl/blink_timing_ctrl.sv
module blink_timing_ctrl #(
  parameter int unsigned BASE_DIV  = 15360,
  parameter int unsigned NORM_MULT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [1:0] rate_code,
  input  logic       bank_mode,
  input  logic       low_power,
  input  logic       disp_on,
  output logic       disp_blank,
  output logic       bank_sel
);
  import blink_pkg::*;

  localparam longint unsigned MAX_HALF = longint'(BASE_DIV) * NORM_MULT * 2;
  localparam int unsigned CW = $clog2(MAX_HALF + 1);

  logic [1:0]    prev_code;
  logic          restart;
  logic          run;
  logic          phase;
  logic [CW-1:0] half_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_code <= RATE_OFF;
    else        prev_code <= rate_code;
  end

  assign restart = (rate_code != prev_code);
  assign run     = (rate_code != RATE_OFF);

  blink_ratio_sel #(
    .BASE_DIV (BASE_DIV),
    .NORM_MULT(NORM_MULT),
    .CW       (CW)
  ) u_ratio (
    .rate_code(rate_code),
    .low_power(low_power),
    .half_lim (half_lim)
  );

  blink_divider #(.CW(CW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .run     (run),
    .restart (restart),
    .half_lim(half_lim),
    .phase   (phase)
  );

  blink_out_map u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .run       (run),
    .restart   (restart),
    .bank_mode (bank_mode),
    .disp_on   (disp_on),
    .disp_blank(disp_blank),
    .bank_sel  (bank_sel)
  );
endmodule

// File: tb/sim_blink_timing_ctrl.sv
module sim_blink_timing_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 8;
  localparam int MULT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic [1:0] rate_code = 2'b00;
  logic bank_mode = 1'b0;
  logic low_power = 1'b0;
  logic disp_on = 1'b1;
  logic disp_blank, bank_sel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blink_timing_ctrl #(.BASE_DIV(BASE), .NORM_MULT(MULT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_code(rate_code),
    .bank_mode(bank_mode), .low_power(low_power), .disp_on(disp_on),
    .disp_blank(disp_blank), .bank_sel(bank_sel)
  );

  function automatic int half_of(input logic [1:0] code, input logic lp);
    int full;
    if (code == 2'b00) return 0;
    full = (lp ? BASE : BASE * MULT) << (code - 1);
    return full / 2;
  endfunction

  // Tick-level reference model
  int m_cnt = 0;
  logic m_phase = 1'b0;
  logic [1:0] m_prev = 2'b00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_phase <= 1'b0; m_prev <= 2'b00;
    end else begin
      m_prev <= rate_code;
      if (rate_code == 2'b00 || rate_code != m_prev) begin
        m_cnt <= 0; m_phase <= 1'b0;
      end else if (tick_en) begin
        if (m_cnt + 1 >= half_of(rate_code, low_power)) begin
          m_cnt <= 0; m_phase <= ~m_phase;
        end else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_compare();
    logic eff;
    string tag;
    eff = m_phase && rate_code != 2'b00 && rate_code == m_prev;
    if (rate_code == 2'b00) tag = "R1";
    else if (rate_code != m_prev) tag = "R8";
    else if (!disp_on) tag = "R7";
    else if (bank_mode) tag = "R6";
    else tag = "R5";
    check(tag, disp_blank, !disp_on || (eff && !bank_mode), "disp_blank");
    check(tag, bank_sel, eff && bank_mode, "bank_sel");
  endtask

  // Measures edges until the first toggle and the length of the high half.
  task automatic measure(input logic [1:0] code, input logic lp, input string req);
    int n;
    int h;
    h = half_of(code, lp);
    @(negedge clk);
    rate_code = 2'b00; low_power = lp; bank_mode = 1'b0; disp_on = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    rate_code = code;
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (!disp_blank && n < 1000);
    check_int(req, n, h + 1, "edges to first blank");
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (disp_blank && n < 1000);
    check_int("R4", n, h, "high half length");
  endtask

  initial begin
    $urandom(32'h1b1c);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 and R1: reset state with rate off
    check("R10", disp_blank, 1'b0, "disp_blank after reset");
    check("R1", bank_sel, 1'b0, "bank_sel after reset");
    disp_on = 1'b0; #1;
    check("R7", disp_blank, 1'b1, "disp_on low");
    disp_on = 1'b1;

    for (int c = 1; c <= 3; c++) measure(2'(c), 1'b0, "R2");
    for (int c = 1; c <= 3; c++) measure(2'(c), 1'b1, "R3");

    // R4: no advance without ticks
    @(negedge clk); rate_code = 2'b00;
    @(negedge clk); rate_code = 2'b01; low_power = 1'b1;
    tick_en = 1'b0;
    repeat (50) @(negedge clk);
    check("R4", disp_blank, 1'b0, "held without ticks");

    // R6: bank mode toggles bank, never blanks
    bank_mode = 1'b1; tick_en = 1'b1;
    repeat (5) @(negedge clk);
    check("R6", bank_sel, 1'b1, "bank_sel second half");
    check("R6", disp_blank, 1'b0, "no blank in bank mode");

    // R8: rate change during second half shows bank 0 immediately
    rate_code = 2'b10; #1;
    check("R8", bank_sel, 1'b0, "bank_sel same cycle after change");
    bank_mode = 1'b0;
    @(negedge clk);
    check("R8", disp_blank, 1'b0, "visible after restart");

    // R9: switch to power-saving family mid-period
    rate_code = 2'b00; low_power = 1'b0;
    @(negedge clk); rate_code = 2'b11;
    repeat (61) @(negedge clk);
    check("R9", disp_blank, 1'b0, "still first half before switch");
    low_power = 1'b1;
    @(negedge clk);
    check("R9", disp_blank, 1'b1, "wrap on next tick after switch");

    // Random run against model
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      model_compare();
      tick_en = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 299) == 0) rate_code = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 499) == 0) low_power = ~low_power;
      if ($urandom_range(0, 199) == 0) bank_mode = ~bank_mode;
      if ($urandom_range(0, 99) == 0) disp_on = ~disp_on;
      #1;
      model_compare();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule